// File: doc/BRIEF.md
# Three-Colour Linear CCD Drive Timing Generator

This block produces every digital drive signal for a three-row colour line-scan CCD from a single system clock. It drives the two complementary shift-register clocks, the per-pixel reset gate pulse, one transfer-gate pulse shared by all three colour rows, and the two-bit colour selection that picks which row reaches the sensor output. Every timing value is a parameter counted in system clocks.

Each line begins with a transfer phase. The shift clocks freeze, the transfer gate opens inside guard intervals, and the reset gate keeps pulsing at the pixel rate throughout. A readout phase follows. It is labelled pixel by pixel as dark reference, active or trailing, and carries a pixel index and a one-clock sample strobe for an external converter. Two inputs are taken at the first clock of each line: the readout length in pixels and the colour mode. The mode is either one colour per line, stepping through the rows from line to line, or all three colours in turn inside every pixel period.

Top module: `ccdLineTimer`

## Requirements
- R1: While `rst` is high, the outputs read phi1=1, phi2=0, phiRb=0, phiTg=0, lineStart=0, sampleStb=0, pixClass=0, pixIdx=0 and colorSel=2'b01 (red).
- R2: phi2 is always the inverse of phi1. In readout, phi1 is high for the first PIX_CLKS/2 clocks of each pixel period and low for the rest.
- R3: lineStart is high for exactly the first clock of each line. A line is a transfer phase followed by a readout. The transfer phase lasts ceil((2*GUARD_CLKS+TG_CLKS)/PIX_CLKS) pixel periods, with phi1 held at 1. The readout lasts the latched length in pixel periods.
- R4: phiTg rises GUARD_CLKS clocks after the line's first clock and stays high for TG_CLKS clocks. phi1 has no edge within GUARD_CLKS clocks before the rise or after the fall.
- R5: In every pixel period, in both transfer and readout, phiRb is high for RB_WIDTH clocks starting RB_LEAD clocks after the period begins. Successive rises are at least 250 ns apart.
- R6: pixClass reads 0 in the transfer phase. In readout it reads 1 for the first OB_PIX pixels, 2 for the next VALID_PIX pixels, and 3 for the rest. pixIdx holds the readout pixel number, from 0, for the whole pixel period, and reads 0 in transfer.
- R7: sampleStb is high for one clock, at offset SAMPLE_CLK, in each readout pixel period, and never in the transfer phase.
- R8: colorSel = {select1, select2} uses 2'b01 for red, 2'b10 for green and 2'b11 for blue. 2'b00 is never driven.
- R9: With colorMode=0, the line with number n counted from reset (the first line is 0) selects red, green, blue for n mod 3 = 0, 1, 2. The selection holds for the whole line.
- R10: With colorMode=1, each pixel period selects red for clocks [0, PIX_CLKS/3), green for [PIX_CLKS/3, 2*(PIX_CLKS/3)) and blue for the rest.
- R11: lineLen and colorMode are sampled on the clock before a line's lineStart appears. Changes at any other time take effect only at the next line.
- R12: A lineLen below OB_PIX+VALID_PIX+TAIL_PIX is treated as that minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lineLen | input | LEN_W | Readout pixel periods per line |
| colorMode | input | 1 | 0: colour per line, 1: rotating inside each pixel |
| phi1 | output | 1 | Shift-register clock, phase 1 |
| phi2 | output | 1 | Shift-register clock, phase 2 |
| phiRb | output | 1 | Reset gate pulse |
| phiTg | output | 1 | Transfer-gate pulse shared by the three rows |
| colorSel | output | 2 | Colour select {select1, select2} |
| lineStart | output | 1 | First clock of a line |
| sampleStb | output | 1 | Converter sample strobe |
| pixClass | output | 2 | Pixel class of the current period |
| pixIdx | output | LEN_W | Readout pixel number |

## Verification
A wrong pixel-phase count moves phiRb, the phi1 edges and the sample strobe inside the very next pixel period, so it shows up within a few dozen clocks. A wrong pixel counter or a wrong phase flag shifts the class boundaries or the lineStart spacing, and this is visible by the end of the line. A wrong colour index or latched mode shows in colorSel from the next line's first clock. The short-length and mid-line-change cases show whether the line length was clamped and latched correctly, because the next lineStart arrives one whole pixel period or more off.

// File: rtl/ccdTimerPkg.sv
`timescale 1ns/1ps
package ccdTimerPkg;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_DARK   = 2'd1,
    CLS_ACTIVE = 2'd2,
    CLS_TAIL   = 2'd3
  } pixClass_e;

  localparam logic [1:0] SEL_RED   = 2'b01;
  localparam logic [1:0] SEL_GREEN = 2'b10;
  localparam logic [1:0] SEL_BLUE  = 2'b11;

  typedef struct packed {
    logic      lineStart;
    logic      phiHold;
    logic      phiFlip;
    logic      tgOn;
    logic      rbOn;
    logic      sample;
    pixClass_e cls;
    logic [1:0] sel;
  } strobe_t;

endpackage

// File: rtl/ccdTimerCtrl.sv
`timescale 1ns/1ps
module ccdTimerCtrl
  import ccdTimerPkg::*;
#(
  parameter int PIX_CLKS   = 50,
  parameter int RB_LEAD    = 13,
  parameter int RB_WIDTH   = 3,
  parameter int GUARD_CLKS = 50,
  parameter int TG_CLKS    = 500,
  parameter int SAMPLE_CLK = 40,
  parameter int OB_PIX     = 48,
  parameter int VALID_PIX  = 2700,
  parameter int TAIL_PIX   = 21,
  parameter int LEN_W      = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] lineLen,
  input  logic             colorMode,
  output strobe_t          stb,
  output logic [LEN_W-1:0] idx
);

  localparam int HALF      = PIX_CLKS / 2;
  localparam int SLOT      = PIX_CLKS / 3;
  localparam int XFER_PIX  = (2 * GUARD_CLKS + TG_CLKS + PIX_CLKS - 1) / PIX_CLKS;
  localparam int XFER_CLKS = XFER_PIX * PIX_CLKS;
  localparam int MIN_LINE  = OB_PIX + VALID_PIX + TAIL_PIX;
  localparam int PC_W      = $clog2(PIX_CLKS);
  localparam int XT_W      = $clog2(XFER_CLKS + 1);

  localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(PIX_CLKS - 1);
  localparam logic [PC_W-1:0]  PC_HALF  = PC_W'(HALF);
  localparam logic [PC_W-1:0]  PC_SLOT1 = PC_W'(SLOT);
  localparam logic [PC_W-1:0]  PC_SLOT2 = PC_W'(2 * SLOT);
  localparam logic [PC_W-1:0]  PC_RBBEG = PC_W'(RB_LEAD);
  localparam logic [PC_W-1:0]  PC_RBEND = PC_W'(RB_LEAD + RB_WIDTH);
  localparam logic [PC_W-1:0]  PC_SMP   = PC_W'(SAMPLE_CLK);
  localparam logic [XT_W-1:0]  XT_TGBEG = XT_W'(GUARD_CLKS);
  localparam logic [XT_W-1:0]  XT_TGEND = XT_W'(GUARD_CLKS + TG_CLKS);
  localparam logic [LEN_W-1:0] LN_MIN   = LEN_W'(MIN_LINE);
  localparam logic [LEN_W-1:0] LN_DARK  = LEN_W'(OB_PIX);
  localparam logic [LEN_W-1:0] LN_ACT   = LEN_W'(OB_PIX + VALID_PIX);
  localparam logic [LEN_W-1:0] LN_XLAST = LEN_W'(XFER_PIX - 1);

  logic [PC_W-1:0]  pc;
  logic             inXfer;
  logic [LEN_W-1:0] pixCnt;
  logic [LEN_W-1:0] lenQ;
  logic             modeQ;
  logic [1:0]       colorIdx;

  logic             lineFirst;
  logic [LEN_W-1:0] lenIn;
  logic [LEN_W-1:0] lenEff;
  logic             modeEff;
  logic [XT_W-1:0]  xferT;
  logic             pcLast;

  assign lineFirst = inXfer && (pixCnt == '0) && (pc == '0);
  assign lenIn     = (lineLen < LN_MIN) ? LN_MIN : lineLen;
  assign lenEff    = lineFirst ? lenIn : lenQ;
  assign modeEff   = lineFirst ? colorMode : modeQ;
  assign xferT     = XT_W'(pixCnt) * XT_W'(PIX_CLKS) + XT_W'(pc);
  assign pcLast    = (pc == PC_LAST);

  // Line sequencing: free-running pixel phase, phase flag, pixel counter
  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      inXfer   <= 1'b1;
      pixCnt   <= '0;
      lenQ     <= LN_MIN;
      modeQ    <= 1'b0;
      colorIdx <= 2'd0;
    end else begin
      if (lineFirst) begin
        lenQ  <= lenIn;
        modeQ <= colorMode;
      end
      if (pcLast) begin
        pc <= '0;
        if (inXfer) begin
          if (pixCnt == LN_XLAST) begin
            inXfer <= 1'b0;
            pixCnt <= '0;
          end else begin
            pixCnt <= pixCnt + 1'b1;
          end
        end else if (pixCnt == lenEff - 1'b1) begin
          inXfer   <= 1'b1;
          pixCnt   <= '0;
          colorIdx <= (colorIdx == 2'd2) ? 2'd0 : colorIdx + 2'd1;
        end else begin
          pixCnt <= pixCnt + 1'b1;
        end
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  // Strobe decode for the current position
  always_comb begin
    stb           = '0;
    stb.lineStart = lineFirst;
    stb.phiHold   = inXfer;
    stb.phiFlip   = !inXfer && (((pc == '0) && (pixCnt != '0)) || (pc == PC_HALF));
    stb.tgOn      = inXfer && (xferT >= XT_TGBEG) && (xferT < XT_TGEND);
    stb.rbOn      = (pc >= PC_RBBEG) && (pc < PC_RBEND);
    stb.sample    = !inXfer && (pc == PC_SMP);
    if (inXfer)                stb.cls = CLS_NONE;
    else if (pixCnt < LN_DARK) stb.cls = CLS_DARK;
    else if (pixCnt < LN_ACT)  stb.cls = CLS_ACTIVE;
    else                       stb.cls = CLS_TAIL;
    if (modeEff) begin
      if (pc < PC_SLOT1)      stb.sel = SEL_RED;
      else if (pc < PC_SLOT2) stb.sel = SEL_GREEN;
      else                    stb.sel = SEL_BLUE;
    end else begin
      case (colorIdx)
        2'd0:    stb.sel = SEL_RED;
        2'd1:    stb.sel = SEL_GREEN;
        default: stb.sel = SEL_BLUE;
      endcase
    end
    idx = inXfer ? '0 : pixCnt;
  end

  AST_XFER_BOUND: assert property (@(posedge clk) disable iff (rst)
    inXfer |-> (pixCnt <= LN_XLAST)); // R3

  AST_READ_BOUND: assert property (@(posedge clk) disable iff (rst)
    !inXfer |-> (pixCnt < lenQ)); // R12

  AST_COLOR_STEP: assert property (@(posedge clk) disable iff (rst)
    (colorIdx != $past(colorIdx)) |-> lineFirst); // R9

endmodule

// File: rtl/ccdTimerDp.sv
`timescale 1ns/1ps
module ccdTimerDp
  import ccdTimerPkg::*;
#(
  parameter int CLK_NS     = 20,
  parameter int GUARD_CLKS = 50,
  parameter int LEN_W      = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [LEN_W-1:0] idxIn,
  output logic             phi1,
  output logic             phi2,
  output logic             phiRb,
  output logic             phiTg,
  output logic [1:0]       colorSel,
  output logic             lineStart,
  output logic             sampleStb,
  output logic [1:0]       pixClass,
  output logic [LEN_W-1:0] pixIdx
);

  localparam int AGE_W     = 16;
  localparam int MIN_RB_NS = 250;

  logic             phi1Q;
  logic             phi1Next;
  logic             rbQ;
  logic             tgQ;
  logic [1:0]       selQ;
  logic             startQ;
  logic             smpQ;
  logic [1:0]       clsQ;
  logic [LEN_W-1:0] idxQ;

  // Timing monitors used by the guard assertions
  logic [AGE_W-1:0] phiAge;
  logic [AGE_W-1:0] tgLow;
  logic [AGE_W-1:0] rbGap;
  logic             rbPrev;

  // Single toggle register for both shift phases
  always_comb begin
    if (stb.phiHold)      phi1Next = 1'b1;
    else if (stb.phiFlip) phi1Next = ~phi1Q;
    else                  phi1Next = phi1Q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phi1Q  <= 1'b1;
      rbQ    <= 1'b0;
      tgQ    <= 1'b0;
      selQ   <= SEL_RED;
      startQ <= 1'b0;
      smpQ   <= 1'b0;
      clsQ   <= 2'd0;
      idxQ   <= '0;
    end else begin
      phi1Q  <= phi1Next;
      rbQ    <= stb.rbOn;
      tgQ    <= stb.tgOn;
      selQ   <= stb.sel;
      startQ <= stb.lineStart;
      smpQ   <= stb.sample;
      clsQ   <= stb.cls;
      idxQ   <= idxIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phiAge <= '0;
      tgLow  <= '1;
      rbGap  <= '1;
      rbPrev <= 1'b0;
    end else begin
      if (phi1Next != phi1Q)  phiAge <= '0;
      else if (phiAge != '1)  phiAge <= phiAge + 1'b1;
      if (tgQ)                tgLow <= '0;
      else if (tgLow != '1)   tgLow <= tgLow + 1'b1;
      if (rbQ && !rbPrev)     rbGap <= AGE_W'(1);
      else if (rbGap != '1)   rbGap <= rbGap + 1'b1;
      rbPrev <= rbQ;
    end
  end

  assign phi1      = phi1Q;
  assign phi2      = ~phi1Q;
  assign phiRb     = rbQ;
  assign phiTg     = tgQ;
  assign colorSel  = selQ;
  assign lineStart = startQ;
  assign sampleStb = smpQ;
  assign pixClass  = clsQ;
  assign pixIdx    = idxQ;

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    selQ != 2'b00); // R8

  AST_TG_GUARD_PRE: assert property (@(posedge clk) disable iff (rst)
    $rose(tgQ) |-> (32'(phiAge) >= GUARD_CLKS)); // R4

  AST_TG_GUARD_POST: assert property (@(posedge clk) disable iff (rst)
    (phi1Q != $past(phi1Q)) |-> (32'(tgLow) >= GUARD_CLKS)); // R4

  AST_TG_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    tgQ |-> (clsQ == 2'd0)); // R4

  AST_RB_PERIOD: assert property (@(posedge clk) disable iff (rst)
    $rose(rbQ) |-> ((32'(rbGap) * CLK_NS) >= MIN_RB_NS)); // R5

  AST_CLASS_ORDER: assert property (@(posedge clk) disable iff (rst)
    (clsQ != $past(clsQ)) |-> (clsQ == 2'($past(clsQ) + 2'd1))); // R6

  AST_SAMPLE_CLASSED: assert property (@(posedge clk) disable iff (rst)
    smpQ |-> (clsQ != 2'd0)); // R7

endmodule

// File: rtl/ccdLineTimer.sv
`timescale 1ns/1ps
module ccdLineTimer
  import ccdTimerPkg::*;
#(
  parameter int CLK_NS     = 20,
  parameter int PIX_CLKS   = 50,
  parameter int RB_LEAD    = 13,
  parameter int RB_WIDTH   = 3,
  parameter int GUARD_CLKS = 50,
  parameter int TG_CLKS    = 500,
  parameter int SAMPLE_CLK = 40,
  parameter int OB_PIX     = 48,
  parameter int VALID_PIX  = 2700,
  parameter int TAIL_PIX   = 21,
  parameter int LEN_W      = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] lineLen,
  input  logic             colorMode,
  output logic             phi1,
  output logic             phi2,
  output logic             phiRb,
  output logic             phiTg,
  output logic [1:0]       colorSel,
  output logic             lineStart,
  output logic             sampleStb,
  output logic [1:0]       pixClass,
  output logic [LEN_W-1:0] pixIdx
);

  strobe_t          stb;
  logic [LEN_W-1:0] idx;

  ccdTimerCtrl #(
    .PIX_CLKS  (PIX_CLKS),
    .RB_LEAD   (RB_LEAD),
    .RB_WIDTH  (RB_WIDTH),
    .GUARD_CLKS(GUARD_CLKS),
    .TG_CLKS   (TG_CLKS),
    .SAMPLE_CLK(SAMPLE_CLK),
    .OB_PIX    (OB_PIX),
    .VALID_PIX (VALID_PIX),
    .TAIL_PIX  (TAIL_PIX),
    .LEN_W     (LEN_W)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .lineLen  (lineLen),
    .colorMode(colorMode),
    .stb      (stb),
    .idx      (idx)
  );

  ccdTimerDp #(
    .CLK_NS    (CLK_NS),
    .GUARD_CLKS(GUARD_CLKS),
    .LEN_W     (LEN_W)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .idxIn    (idx),
    .phi1     (phi1),
    .phi2     (phi2),
    .phiRb    (phiRb),
    .phiTg    (phiTg),
    .colorSel (colorSel),
    .lineStart(lineStart),
    .sampleStb(sampleStb),
    .pixClass (pixClass),
    .pixIdx   (pixIdx)
  );

endmodule

// File: tb/test_ccdLineTimer.sv
`timescale 1ns/1ps
module test_ccdLineTimer;

  localparam int CLK_NS     = 20;
  localparam int PIX_CLKS   = 50;
  localparam int RB_LEAD    = 13;
  localparam int RB_WIDTH   = 3;
  localparam int GUARD_CLKS = 50;
  localparam int TG_CLKS    = 150;
  localparam int SAMPLE_CLK = 40;
  localparam int OB_PIX     = 4;
  localparam int VALID_PIX  = 10;
  localparam int TAIL_PIX   = 3;
  localparam int LEN_W      = 13;

  localparam int HALF      = PIX_CLKS / 2;
  localparam int SLOT      = PIX_CLKS / 3;
  localparam int XFER_CLKS = ((2 * GUARD_CLKS + TG_CLKS + PIX_CLKS - 1) / PIX_CLKS) * PIX_CLKS;
  localparam int MIN_LINE  = OB_PIX + VALID_PIX + TAIL_PIX;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LEN_W-1:0] lineLen = '0;
  logic             colorMode = 1'b0;
  logic             phi1, phi2, phiRb, phiTg, lineStart, sampleStb;
  logic [1:0]       colorSel, pixClass;
  logic [LEN_W-1:0] pixIdx;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  ccdLineTimer #(
    .CLK_NS(CLK_NS), .PIX_CLKS(PIX_CLKS), .RB_LEAD(RB_LEAD), .RB_WIDTH(RB_WIDTH),
    .GUARD_CLKS(GUARD_CLKS), .TG_CLKS(TG_CLKS), .SAMPLE_CLK(SAMPLE_CLK),
    .OB_PIX(OB_PIX), .VALID_PIX(VALID_PIX), .TAIL_PIX(TAIL_PIX), .LEN_W(LEN_W)
  ) i_ccdLineTimer (
    .clk(clk), .rst(rst), .lineLen(lineLen), .colorMode(colorMode),
    .phi1(phi1), .phi2(phi2), .phiRb(phiRb), .phiTg(phiTg), .colorSel(colorSel),
    .lineStart(lineStart), .sampleStb(sampleStb), .pixClass(pixClass), .pixIdx(pixIdx)
  );

  task automatic check(input string tag, input int nBad, input int act, input int exp);
    vectors++;
    if (nBad != 0) begin
      fails++;
      $display("FAIL %s: %0d bad cycles, actual %0d expected %0d", tag, nBad, act, exp);
    end
  endtask

  task automatic note(inout int n, inout int a, inout int e, input int act, input int exp);
    if (act != exp) begin
      if (n == 0) begin
        a = act;
        e = exp;
      end
      n++;
    end
  endtask

  function automatic int selCode(input int c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 3;
  endfunction

  // R1: values held during reset
  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 phi1/phi2", 0, {phi1, phi2}, 2);
    check("R1 phi1/phi2", ({phi1, phi2} != 2'b10) ? 1 : 0, {phi1, phi2}, 2);
    check("R1 phiRb/phiTg", (phiRb || phiTg) ? 1 : 0, {phiRb, phiTg}, 0);
    check("R1 strobes", (lineStart || sampleStb) ? 1 : 0, {lineStart, sampleStb}, 0);
    check("R1 class/index", (pixClass != 0 || pixIdx != 0) ? 1 : 0, pixClass, 0);
    check("R1 colour", (colorSel != 2'b01) ? 1 : 0, colorSel, 1);
    rst = 1'b0;
  endtask

  // One full line checked cycle by cycle; next-line inputs applied mid-line (R11)
  task automatic runLine(input int expLen, input bit mode, input int col,
                         input int nxtLen, input bit nxtMode, input string lenTag);
    int nPhi = 0, aPhi = 0, ePhi = 0;
    int nSt = 0, aSt = 0, eSt = 0;
    int nTg = 0, aTg = 0, eTg = 0;
    int nRb = 0, aRb = 0, eRb = 0;
    int nCl = 0, aCl = 0, eCl = 0;
    int nSm = 0, aSm = 0, eSm = 0;
    int nSe = 0, aSe = 0, eSe = 0;
    int nLe = 0, aLe = 0, eLe = 0;
    int nIl = 0, aIl = 0, eIl = 0;
    int total = XFER_CLKS + expLen * PIX_CLKS;
    while (!lineStart) @(negedge clk);
    for (int t = 0; t < total; t++) begin
      bit inX = (t < XFER_CLKS);
      int r = t - XFER_CLKS;
      int p = inX ? 0 : r / PIX_CLKS;
      int q = inX ? 0 : r % PIX_CLKS;
      int q0 = t % PIX_CLKS;
      int ePh = inX ? 1 : ((q < HALF) ? 1 : 0);
      int eC = inX ? 0 : (p < OB_PIX) ? 1 : (p < OB_PIX + VALID_PIX) ? 2 : 3;
      int eS = mode ? ((q0 < SLOT) ? 1 : (q0 < 2 * SLOT) ? 2 : 3) : selCode(col);
      note(nPhi, aPhi, ePhi, {phi1, phi2}, ePh ? 2 : 1);
      note(nSt, aSt, eSt, lineStart, (t == 0) ? 1 : 0);
      note(nTg, aTg, eTg, phiTg, (t >= GUARD_CLKS && t < GUARD_CLKS + TG_CLKS) ? 1 : 0);
      note(nRb, aRb, eRb, phiRb, (q0 >= RB_LEAD && q0 < RB_LEAD + RB_WIDTH) ? 1 : 0);
      note(nCl, aCl, eCl, pixClass * 65536 + int'(pixIdx), eC * 65536 + p);
      note(nSm, aSm, eSm, sampleStb, (!inX && q == SAMPLE_CLK) ? 1 : 0);
      note(nSe, aSe, eSe, colorSel, eS);
      note(nIl, aIl, eIl, (colorSel == 2'b00) ? 1 : 0, 0);
      if (t > 100) note(nLe, aLe, eLe, colorSel * 4 + pixClass, eS * 4 + eC);
      if (t == 100) begin
        lineLen   = LEN_W'(nxtLen);
        colorMode = nxtMode;
      end
      @(negedge clk);
    end
    check("R2 phi1/phi2 shape", nPhi, aPhi, ePhi);
    check("R3 lineStart single clock", nSt, aSt, eSt);
    check("R4 transfer window", nTg, aTg, eTg);
    check("R5 reset gate pulse", nRb, aRb, eRb);
    check("R6 class*65536+index", nCl, aCl, eCl);
    check("R7 sample strobe", nSm, aSm, eSm);
    check("R8 no prohibited select", nIl, aIl, eIl);
    check(mode ? "R10 rotating select" : "R9 per-line select", nSe, aSe, eSe);
    check("R11 late input change ignored", nLe, aLe, eLe);
    check({lenTag, " next lineStart after line length"}, lineStart ? 0 : 1, lineStart, 1);
  endtask

  initial begin
    testReset();
    runLine(MIN_LINE, 1'b0, 0, 20, 1'b0, "R12");        // length 0 clamps
    runLine(20, 1'b0, 1, 5, 1'b1, "R3");
    runLine(MIN_LINE, 1'b1, 2, 18, 1'b0, "R12");        // length 5 clamps
    runLine(18, 1'b0, 0, MIN_LINE, 1'b1, "R3");
    runLine(MIN_LINE, 1'b1, 1, MIN_LINE, 1'b1, "R3");   // exactly the minimum
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule